// File: doc/BRIEF.md
# Data Cache Maintenance Command Unit

This block carries out cache-management commands against a two-way, set-associative data cache. It holds the tag and data storage of that cache. A command is made of a 5-bit operation code, a 32-bit effective address and a 32-bit tag-register value. The unit decodes the command and runs it through a short state sequence. When the unit is idle it accepts one command, raises `busy`, and finishes with a one-cycle `done` pulse. At that pulse the tag-register result and an unsupported-operation flag are valid.

Commands come in two addressing styles. Hit-style commands select the set from address bits 11:6 and compare the line tag (address bits 31:12) against both ways. A miss completes with no effect. Index-style commands select the set from bits 11:6 and the way from bit 0, with no tag compare. Either style can invalidate a line or write it back. A write-back streams a dirty, valid line to memory one 32-bit word per accepted transfer, in ascending address order. Index commands can also read or write one tag or one data word directly through the tag-register value, so software can preload and inspect the cache.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset `busy`, `done`, `unsupported` and `mem_wr_valid` are 0, and every line reads back with tag 0 and all flags 0. In a line's flag field, bit 6 is dirty, bit 5 is valid, bit 4 is least-recently-filled and bit 3 is lock.
- R2: Op 0x1A (hit invalidate) clears the matching line without any memory write. Clearing sets the tag to 0, sets every flag except least-recently-filled to 0, and zeroes all 16 data words.
- R3: A hit-style command (0x1A, 0x18, 0x1C) whose address tag matches no valid line in the set completes with no memory write and no change to the cache.
- R4: Op 0x18 (hit write-back invalidate) first writes a dirty, valid matching line to memory as 16 words, then clears it. Word k goes to address {line tag, set, k, 2'b00}, with k ascending.
- R5: Op 0x1C (hit write-back) writes a dirty, valid matching line back the same way, then clears only its dirty flag. The tag, valid flag and data are kept.
- R6: Index-style commands use address bits 11:6 as the set and bit 0 as the way, and ignore address bits 31:12. Op 0x16 (index invalidate) clears the line even when it is dirty, and writes nothing to memory.
- R7: Op 0x14 (index write-back invalidate) writes the addressed line back if it is dirty and valid, then clears it.
- R8: Op 0x11 returns the data word selected by address bits 5:2 of the addressed line. Op 0x13 stores the tag-register value into that word and leaves the other words unchanged.
- R9: Op 0x12 sets the line tag from tag-register bits 31:12 and the flags from bits 10:0. Op 0x10 writes the line back if it is dirty and valid, then returns {tag, 1'b0, flags}, with the dirty flag cleared by that write-back.
- R10: Ops 0x07 and 0x0C complete with no effect and `unsupported` low. Any code that no other requirement names completes with no effect and pulses `unsupported` together with `done`.
- R11: Every clear keeps the line's least-recently-filled flag.
- R12: While `busy` is high, `cmd_valid` is ignored. `done` lasts exactly one cycle. While `mem_wr_valid` is high and `mem_wr_ready` is low, the write address and data stay stable.
- R13: A line that is dirty but not valid is never written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 5 | Operation code |
| cmd_addr | input | 32 | Effective address |
| cmd_taglo | input | 32 | Tag-register value for store commands |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | Unknown operation code, valid with done |
| res_taglo | output | 32 | Tag-register result of load commands |
| mem_wr_valid | output | 1 | Write-back word valid |
| mem_wr_addr | output | 32 | Write-back byte address |
| mem_wr_data | output | 32 | Write-back data word |
| mem_wr_ready | input | 1 | Memory accepts the write-back word |

## Verification
The bench puts lines into chosen states with store-tag and store-word commands: clean valid, dirty valid, dirty invalid, and lines with the recently-filled or lock bits set. It then runs each maintenance command on them. Hit commands are run with a matching tag, with a tag that differs in one bit, and with the other way of the set occupied, which separates a correct compare and way choice from a plain index. Index commands are given addresses whose upper bits are set, to show those bits are ignored. Write-backs run both with memory always ready and with a stalling ready, which tests word order, address formation and holding the data during a stall.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

   localparam int FLAG_W   = 11;
   localparam int FL_DIRTY = 6;
   localparam int FL_VALID = 5;
   localparam int FL_LRF   = 4;
   localparam int FL_LOCK  = 3;
   localparam int WORD_W   = 32;

   typedef enum logic [4:0] {
      OP_ICACHE_IDX_INV = 5'h07,
      OP_BTC_FLUSH      = 5'h0C,
      OP_IDX_LOAD_TAG   = 5'h10,
      OP_IDX_LOAD_WORD  = 5'h11,
      OP_IDX_STORE_TAG  = 5'h12,
      OP_IDX_STORE_WORD = 5'h13,
      OP_IDX_WB_INV     = 5'h14,
      OP_IDX_INV        = 5'h16,
      OP_HIT_WB_INV     = 5'h18,
      OP_HIT_INV        = 5'h1A,
      OP_HIT_WB         = 5'h1C
   } maint_op_e;

   typedef struct packed {
      logic hit_mode;
      logic nop;
      logic unimpl;
      logic wb;
      logic clear;
      logic rd_word;
      logic wr_word;
      logic rd_tag;
      logic wr_tag;
   } maint_ctl_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WB,
      ST_APPLY,
      ST_DONE
   } maint_state_e;

endpackage

// File: rtl/cmu_decode.sv
module cmu_decode
   import cmu_pkg::*;
(
   input  logic [4:0] op,
   output maint_ctl_t ctl
);

   always_comb begin
      ctl = '0;
      case (op)
         OP_ICACHE_IDX_INV,
         OP_BTC_FLUSH:      ctl.nop = 1'b1;
         OP_HIT_INV: begin
            ctl.hit_mode = 1'b1;
            ctl.clear    = 1'b1;
         end
         OP_HIT_WB_INV: begin
            ctl.hit_mode = 1'b1;
            ctl.wb       = 1'b1;
            ctl.clear    = 1'b1;
         end
         OP_HIT_WB: begin
            ctl.hit_mode = 1'b1;
            ctl.wb       = 1'b1;
         end
         OP_IDX_INV:        ctl.clear = 1'b1;
         OP_IDX_WB_INV: begin
            ctl.wb    = 1'b1;
            ctl.clear = 1'b1;
         end
         OP_IDX_LOAD_WORD:  ctl.rd_word = 1'b1;
         OP_IDX_STORE_WORD: ctl.wr_word = 1'b1;
         OP_IDX_LOAD_TAG: begin
            ctl.wb     = 1'b1;
            ctl.rd_tag = 1'b1;
         end
         OP_IDX_STORE_TAG:  ctl.wr_tag = 1'b1;
         default:           ctl.unimpl = 1'b1;
      endcase
   end

endmodule

// File: rtl/cmu_tag_store.sv
module cmu_tag_store
   import cmu_pkg::*;
#(
   parameter int SETS  = 64,
   parameter int WAYS  = 2,
   parameter int TAG_W = 20,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [SET_W-1:0]              rd_set,
   input  logic [TAG_W-1:0]              cmp_tag,
   output logic [WAYS-1:0][TAG_W-1:0]    rd_tags,
   output logic [WAYS-1:0][FLAG_W-1:0]   rd_flags,
   output logic                          hit,
   output logic [WAY_W-1:0]              hit_way,
   input  logic                          we,
   input  logic [SET_W-1:0]              wr_set,
   input  logic [WAY_W-1:0]              wr_way,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [FLAG_W-1:0]             wr_flags
);

   logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
   logic [FLAG_W-1:0] flag_mem [SETS][WAYS];
   logic [WAYS-1:0]   hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign rd_tags[w]  = tag_mem[rd_set][w];
      assign rd_flags[w] = flag_mem[rd_set][w];
      assign hit_vec[w]  = flag_mem[rd_set][w][FL_VALID] &&
                           (tag_mem[rd_set][w] == cmp_tag);
   end

   // lowest matching way wins
   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
   assign hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_mem[s][w]  <= '0;
               flag_mem[s][w] <= '0;
            end
         end
      end else if (we) begin
         tag_mem[wr_set][wr_way]  <= wr_tag;
         flag_mem[wr_set][wr_way] <= wr_flags;
      end
   end

   // a reported hit always names a valid way holding the compared tag
   assert_hit_way_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (rd_flags[hit_way][FL_VALID] && rd_tags[hit_way] == cmp_tag));

endmodule

// File: rtl/cmu_data_store.sv
module cmu_data_store
   import cmu_pkg::*;
#(
   parameter int SETS  = 64,
   parameter int WAYS  = 2,
   parameter int WORDS = 16,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int WIDX_W = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SET_W-1:0]   set_idx,
   input  logic [WAY_W-1:0]   way_idx,
   input  logic [WIDX_W-1:0]  word_idx,
   output logic [WORD_W-1:0]  rd_word,
   input  logic               clr_line,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  wr_data
);

   logic [WORD_W-1:0] mem [SETS][WAYS][WORDS];

   assign rd_word = mem[set_idx][way_idx][word_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               for (int k = 0; k < WORDS; k++) begin
                  mem[s][w][k] <= '0;
               end
            end
         end
      end else if (clr_line) begin
         for (int k = 0; k < WORDS; k++) begin
            mem[set_idx][way_idx][k] <= '0;
         end
      end else if (wr_en) begin
         mem[set_idx][way_idx][word_idx] <= wr_data;
      end
   end

   // after a line clear the addressed word reads zero
   assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_line |=> ($past(set_idx) != set_idx || $past(way_idx) != way_idx ||
                    rd_word == '0));

endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
   import cmu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 64,
   parameter int WAYS       = 2,
   parameter int LINE_BYTES = 64,
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int WORDS  = LINE_BYTES / 4,
   localparam int WIDX_W = $clog2(WORDS),
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [4:0]         cmd_op,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [31:0]        cmd_taglo,
   output logic               busy,
   output logic               done,
   output logic               unsupported,
   output logic [31:0]        res_taglo,
   output logic               mem_wr_valid,
   output logic [ADDR_W-1:0]  mem_wr_addr,
   output logic [31:0]        mem_wr_data,
   input  logic               mem_wr_ready
);

   // elaboration-time parameter checks
   if (WAYS != 2) begin : g_bad_ways
      $error("cache_maint_unit: way select uses one address bit, WAYS must be 2");
   end
   if (SETS != (1 << SET_W)) begin : g_bad_sets
      $error("cache_maint_unit: SETS must be a power of two");
   end
   if (LINE_BYTES != (1 << OFF_W) || LINE_BYTES < 8) begin : g_bad_line
      $error("cache_maint_unit: LINE_BYTES must be a power of two of at least 8");
   end
   if (ADDR_W != 32) begin : g_bad_addr
      $error("cache_maint_unit: tag register is 32 bits wide, ADDR_W must be 32");
   end
   if (OFF_W + SET_W <= FLAG_W) begin : g_bad_split
      $error("cache_maint_unit: tag field would overlap flag field in tag register");
   end

   maint_state_e state_q;
   maint_ctl_t   ctl_d, ctl_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [31:0]        taglo_q;
   logic [WAY_W-1:0]   way_q;
   logic               wb_q;
   logic               unimpl_q;
   logic [WIDX_W-1:0]  cnt_q;
   logic [31:0]        res_q;

   logic [SET_W-1:0]   set_idx;
   logic [TAG_W-1:0]   addr_tag;
   logic [WIDX_W-1:0]  addr_word;
   logic [WAY_W-1:0]   addr_way;

   logic [WAYS-1:0][TAG_W-1:0]  rd_tags;
   logic [WAYS-1:0][FLAG_W-1:0] rd_flags;
   logic                        hit;
   logic [WAY_W-1:0]            hit_way;

   logic [WAY_W-1:0]   look_way;
   logic [FLAG_W-1:0]  look_flags;
   logic               look_wb;

   logic [TAG_W-1:0]   cur_tag;
   logic [FLAG_W-1:0]  cur_flags;
   logic [TAG_W-1:0]   new_tag;
   logic [FLAG_W-1:0]  new_flags;
   logic               tag_we;

   logic [WIDX_W-1:0]  word_idx;
   logic [31:0]        rd_word;
   logic               clr_line;
   logic               wr_word;
   logic               wb_last;

   assign set_idx   = addr_q[OFF_W +: SET_W];
   assign addr_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign addr_word = addr_q[2 +: WIDX_W];
   assign addr_way  = addr_q[WAY_W-1:0];

   cmu_decode u_decode (
      .op  (cmd_op),
      .ctl (ctl_d)
   );

   cmu_tag_store #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (set_idx),
      .cmp_tag  (addr_tag),
      .rd_tags  (rd_tags),
      .rd_flags (rd_flags),
      .hit      (hit),
      .hit_way  (hit_way),
      .we       (tag_we),
      .wr_set   (set_idx),
      .wr_way   (way_q),
      .wr_tag   (new_tag),
      .wr_flags (new_flags)
   );

   assign word_idx = (state_q == ST_WB) ? cnt_q : addr_word;
   assign clr_line = (state_q == ST_APPLY) && ctl_q.clear;
   assign wr_word  = (state_q == ST_APPLY) && ctl_q.wr_word;

   cmu_data_store #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .WORDS (WORDS)
   ) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_idx  (set_idx),
      .way_idx  (way_q),
      .word_idx (word_idx),
      .rd_word  (rd_word),
      .clr_line (clr_line),
      .wr_en    (wr_word),
      .wr_data  (taglo_q)
   );

   // way choice and write-back need during lookup
   always_comb begin
      look_way   = ctl_q.hit_mode ? hit_way : addr_way;
      look_flags = rd_flags[look_way];
      look_wb    = ctl_q.wb && look_flags[FL_DIRTY] && look_flags[FL_VALID];
   end

   // tag and flag update in the apply step
   always_comb begin
      cur_tag   = rd_tags[way_q];
      cur_flags = rd_flags[way_q];
      new_tag   = cur_tag;
      new_flags = cur_flags;
      if (ctl_q.clear) begin
         new_tag           = '0;
         new_flags         = '0;
         new_flags[FL_LRF] = cur_flags[FL_LRF];
      end else if (ctl_q.wr_tag) begin
         new_tag   = taglo_q[31 -: TAG_W];
         new_flags = taglo_q[FLAG_W-1:0];
      end else if (wb_q) begin
         new_flags[FL_DIRTY] = 1'b0;
      end
      tag_we = (state_q == ST_APPLY) && (ctl_q.clear || ctl_q.wr_tag || wb_q);
   end

   assign wb_last = (cnt_q == WIDX_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ctl_q    <= '0;
         addr_q   <= '0;
         taglo_q  <= '0;
         way_q    <= '0;
         wb_q     <= 1'b0;
         unimpl_q <= 1'b0;
         cnt_q    <= '0;
         res_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  ctl_q    <= ctl_d;
                  addr_q   <= cmd_addr;
                  taglo_q  <= cmd_taglo;
                  unimpl_q <= 1'b0;
                  wb_q     <= 1'b0;
                  state_q  <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               way_q    <= look_way;
               wb_q     <= look_wb;
               cnt_q    <= '0;
               unimpl_q <= ctl_q.unimpl;
               if (ctl_q.nop || ctl_q.unimpl || (ctl_q.hit_mode && !hit)) begin
                  state_q <= ST_DONE;
               end else if (look_wb) begin
                  state_q <= ST_WB;
               end else begin
                  state_q <= ST_APPLY;
               end
            end
            ST_WB: begin
               if (mem_wr_ready) begin
                  if (wb_last) begin
                     state_q <= ST_APPLY;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_APPLY: begin
               if (ctl_q.rd_word) begin
                  res_q <= rd_word;
               end else if (ctl_q.rd_tag) begin
                  res_q <= {new_tag, {(32 - TAG_W - FLAG_W){1'b0}}, new_flags};
               end
               state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign unsupported  = done && unimpl_q;
   assign res_taglo    = res_q;
   assign mem_wr_valid = (state_q == ST_WB);
   assign mem_wr_addr  = {rd_tags[way_q], set_idx, cnt_q, 2'b00};
   assign mem_wr_data  = rd_word;

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_wb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   assert_wb_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> busy);

   assert_unsup_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> done);

   assert_no_cmd_effect_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state_q != ST_DONE) |=> busy);

endmodule

// File: tb/tb_cache_maint_unit.sv
`timescale 1ns/1ps
module tb_cache_maint_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [4:0]  cmd_op = '0;
   logic [31:0] cmd_addr = '0;
   logic [31:0] cmd_taglo = '0;
   logic        busy, done, unsupported;
   logic [31:0] res_taglo;
   logic        mem_wr_valid;
   logic [31:0] mem_wr_addr, mem_wr_data;
   logic        mem_wr_ready = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit stall_en = 1'b0;
   int stall_ctr = 0;
   int wb_n = 0;
   logic [31:0] wb_addr [16];
   logic [31:0] wb_data [16];
   logic [31:0] last_res;
   logic        last_unsup;

   always #2 clk = ~clk;

   cache_maint_unit dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_op       (cmd_op),
      .cmd_addr     (cmd_addr),
      .cmd_taglo    (cmd_taglo),
      .busy         (busy),
      .done         (done),
      .unsupported  (unsupported),
      .res_taglo    (res_taglo),
      .mem_wr_valid (mem_wr_valid),
      .mem_wr_addr  (mem_wr_addr),
      .mem_wr_data  (mem_wr_data),
      .mem_wr_ready (mem_wr_ready)
   );

   always @(negedge clk) begin
      stall_ctr++;
      mem_wr_ready = stall_en ? stall_ctr[1] : 1'b1;
   end

   always @(posedge clk) begin
      if (rst_n && mem_wr_valid && mem_wr_ready) begin
         if (wb_n < 16) begin
            wb_addr[wb_n] = mem_wr_addr;
            wb_data[wb_n] = mem_wr_data;
         end
         wb_n++;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ix(input int set, input int way, input int w);
      return 32'((set << 6) | (w << 2) | way);
   endfunction

   function automatic logic [31:0] hx(input logic [19:0] tag, input int set);
      return {tag, 6'(set), 6'd0};
   endfunction

   function automatic logic [31:0] tv(input logic [19:0] tag, input logic [10:0] fl);
      return {tag, 1'b0, fl};
   endfunction

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12 command never completed: actual=0 expected=1");
      end
      last_res   = res_taglo;
      last_unsup = unsupported;
   endtask

   task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] t);
      @(negedge clk);
      while (busy) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      cmd_taglo = t;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
   endtask

   task automatic store_tag(input int set, input int way, input logic [19:0] tag,
                            input logic [10:0] fl);
      run_op(5'h12, ix(set, way, 0), tv(tag, fl));
   endtask

   task automatic load_tag(input int set, input int way, output logic [31:0] v);
      run_op(5'h10, ix(set, way, 0), 32'h0);
      v = last_res;
   endtask

   task automatic load_word(input int set, input int way, input int w, output logic [31:0] v);
      run_op(5'h11, ix(set, way, w), 32'h0);
      v = last_res;
   endtask

   task automatic test_reset();
      logic [31:0] v;
      chk("R1", "busy after reset", 32'(busy), 32'h0);
      chk("R1", "done after reset", 32'(done), 32'h0);
      chk("R1", "unsupported after reset", 32'(unsupported), 32'h0);
      chk("R1", "mem_wr_valid after reset", 32'(mem_wr_valid), 32'h0);
      wb_n = 0;
      load_tag(5, 1, v);
      chk("R1", "tag of set 5 way 1 after reset", v, 32'h0);
      chk("R1", "no write-back from empty line", 32'(wb_n), 32'h0);
   endtask

   task automatic test_direct_access();
      logic [31:0] v;
      store_tag(3, 1, 20'hABCDE, 11'h020);
      load_tag(3, 1, v);
      chk("R9", "store/load tag", v, tv(20'hABCDE, 11'h020));
      run_op(5'h13, ix(3, 1, 7), 32'h12345678);
      load_word(3, 1, 7, v);
      chk("R8", "stored word 7", v, 32'h12345678);
      load_word(3, 1, 6, v);
      chk("R8", "neighbour word 6 untouched", v, 32'h0);
      load_word(3, 0, 7, v);
      chk("R8", "other way word 7 untouched", v, 32'h0);
   endtask

   task automatic test_hit_inv();
      logic [31:0] v;
      store_tag(10, 0, 20'h11111, 11'h070);
      run_op(5'h13, ix(10, 0, 0), 32'hDEADBEEF);
      wb_n = 0;
      run_op(5'h1A, hx(20'h11111, 10), 32'h0);
      chk("R2", "hit invalidate writes nothing", 32'(wb_n), 32'h0);
      load_tag(10, 0, v);
      chk("R11", "cleared line keeps recently-filled bit", v, tv(20'h0, 11'h010));
      load_word(10, 0, 0, v);
      chk("R2", "cleared line data zero", v, 32'h0);
   endtask

   task automatic test_hit_miss();
      logic [31:0] v;
      store_tag(12, 1, 20'h22222, 11'h060);
      run_op(5'h13, ix(12, 1, 2), 32'hCAFEF00D);
      wb_n = 0;
      run_op(5'h18, hx(20'h22223, 12), 32'h0);
      chk("R3", "miss writes nothing", 32'(wb_n), 32'h0);
      run_op(5'h1A, hx(20'h22220, 12), 32'h0);
      load_word(12, 1, 2, v);
      chk("R3", "miss keeps data", v, 32'hCAFEF00D);
      load_tag(12, 1, v);
      chk("R3", "miss keeps line valid", v, tv(20'h22222, 11'h020));
   endtask

   task automatic test_hit_wb_inv();
      logic [31:0] v;
      bit ok_a = 1'b1;
      bit ok_d = 1'b1;
      store_tag(20, 0, 20'h44444, 11'h020);
      store_tag(20, 1, 20'h33333, 11'h060);
      for (int k = 0; k < 16; k++) run_op(5'h13, ix(20, 1, k), 32'hC0DE0000 + 32'(k));
      wb_n = 0;
      stall_en = 1'b1;
      run_op(5'h18, hx(20'h33333, 20), 32'h0);
      stall_en = 1'b0;
      chk("R4", "write-back word count", 32'(wb_n), 32'd16);
      for (int k = 0; k < 16; k++) begin
         if (wb_addr[k] !== ((32'h33333 << 12) | (32'd20 << 6) | 32'(k << 2))) ok_a = 1'b0;
         if (wb_data[k] !== 32'hC0DE0000 + 32'(k)) ok_d = 1'b0;
      end
      chk("R4", "write-back addresses ascending", 32'(ok_a), 32'h1);
      chk("R12", "write-back data under stall", 32'(ok_d), 32'h1);
      load_tag(20, 1, v);
      chk("R4", "line cleared after write-back", v, 32'h0);
      load_tag(20, 0, v);
      chk("R4", "other way untouched", v, tv(20'h44444, 11'h020));
   endtask

   task automatic test_hit_wb();
      logic [31:0] v;
      store_tag(21, 0, 20'h55555, 11'h060);
      run_op(5'h13, ix(21, 0, 3), 32'h0000FEED);
      wb_n = 0;
      run_op(5'h1C, hx(20'h55555, 21), 32'h0);
      chk("R5", "write-back word count", 32'(wb_n), 32'd16);
      chk("R5", "word 3 written back", wb_data[3], 32'h0000FEED);
      load_tag(21, 0, v);
      chk("R5", "line kept valid, dirty cleared", v, tv(20'h55555, 11'h020));
      load_word(21, 0, 3, v);
      chk("R5", "data kept", v, 32'h0000FEED);
   endtask

   task automatic test_idx_inv();
      logic [31:0] v;
      store_tag(30, 0, 20'h77777, 11'h020);
      store_tag(30, 1, 20'h66666, 11'h060);
      wb_n = 0;
      run_op(5'h16, 32'hFFFFF000 | ix(30, 1, 0), 32'h0);
      chk("R6", "index invalidate writes nothing", 32'(wb_n), 32'h0);
      load_tag(30, 1, v);
      chk("R6", "way 1 cleared", v, 32'h0);
      load_tag(30, 0, v);
      chk("R6", "way 0 untouched", v, tv(20'h77777, 11'h020));
   endtask

   task automatic test_idx_wb_inv();
      logic [31:0] v;
      store_tag(31, 0, 20'h12345, 11'h060);
      run_op(5'h13, ix(31, 0, 15), 32'h0BADCAFE);
      wb_n = 0;
      run_op(5'h14, ix(31, 0, 0), 32'h0);
      chk("R7", "write-back word count", 32'(wb_n), 32'd16);
      chk("R7", "last word address", wb_addr[15],
          (32'h12345 << 12) | (32'd31 << 6) | 32'h3C);
      chk("R7", "last word data", wb_data[15], 32'h0BADCAFE);
      load_tag(31, 0, v);
      chk("R7", "line cleared", v, 32'h0);
   endtask

   task automatic test_load_tag_wb();
      logic [31:0] v;
      store_tag(40, 1, 20'h0F0F0, 11'h068);
      wb_n = 0;
      load_tag(40, 1, v);
      chk("R9", "load tag writes dirty line back", 32'(wb_n), 32'd16);
      chk("R9", "load tag result after write-back", v, tv(20'h0F0F0, 11'h028));
   endtask

   task automatic test_dirty_invalid();
      logic [31:0] v;
      store_tag(41, 0, 20'h00001, 11'h040);
      wb_n = 0;
      run_op(5'h14, ix(41, 0, 0), 32'h0);
      chk("R13", "dirty invalid line not written back", 32'(wb_n), 32'h0);
      load_tag(41, 0, v);
      chk("R13", "line cleared", v, 32'h0);
   endtask

   task automatic test_nop_unsup();
      logic [31:0] v;
      wb_n = 0;
      run_op(5'h07, ix(3, 1, 0), 32'h0);
      chk("R10", "op 07 not flagged", 32'(last_unsup), 32'h0);
      run_op(5'h0C, ix(3, 1, 0), 32'h0);
      chk("R10", "op 0C not flagged", 32'(last_unsup), 32'h0);
      run_op(5'h05, ix(3, 1, 0), 32'h0);
      chk("R10", "op 05 flagged", 32'(last_unsup), 32'h1);
      run_op(5'h1F, ix(3, 1, 0), 32'hFFFFFFFF);
      chk("R10", "op 1F flagged", 32'(last_unsup), 32'h1);
      load_tag(3, 1, v);
      chk("R10", "no-op and unknown ops leave line", v, tv(20'hABCDE, 11'h020));
      chk("R10", "no write-back", 32'(wb_n), 32'h0);
   endtask

   task automatic test_busy();
      logic [31:0] v;
      store_tag(50, 0, 20'h50505, 11'h020);
      store_tag(60, 0, 20'h60606, 11'h060);
      @(negedge clk);
      while (busy) @(negedge clk);
      stall_en = 1'b1;
      cmd_valid = 1'b1;
      cmd_op    = 5'h14;
      cmd_addr  = ix(60, 0, 0);
      cmd_taglo = 32'h0;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12", "busy during write-back", 32'(busy), 32'h1);
      cmd_valid = 1'b1;
      cmd_op    = 5'h16;
      cmd_addr  = ix(50, 0, 0);
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      @(negedge clk);
      chk("R12", "done lasts one cycle", 32'(done), 32'h0);
      stall_en = 1'b0;
      load_tag(50, 0, v);
      chk("R12", "command during busy ignored", v, tv(20'h50505, 11'h020));
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog expired: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_direct_access();
      test_hit_inv();
      test_hit_miss();
      test_hit_wb_inv();
      test_hit_wb();
      test_idx_inv();
      test_idx_wb_inv();
      test_load_tag_wb();
      test_dirty_invalid();
      test_nop_unsup();
      test_busy();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule